// File: doc/BRIEF.md
# Serial Packet Receive Deframer

This block sits behind a bit synchronizer and turns a stream of recovered bits into accepted packet bytes. Each incoming bit arrives with a one-cycle enable. While idle, the block hunts for a programmable sync pattern of up to eight bytes. Once the pattern is found it optionally takes a length byte, optionally screens an address byte, collects the payload into an internal 66-byte FIFO, and verifies a trailing 16-bit CRC. Packets that fail the address screen, or that fail the CRC while automatic discard is in force, are flushed, and the hunt for sync starts again.

A packet that is kept raises a payload-ready flag, and a CRC-ok flag when the CRC matched. Both flags stay up until the consumer has drained the FIFO through its read port. Only then does the block look for the next sync pattern. A fixed-format packet with a programmed length of zero is received without limit: bytes keep flowing into the FIFO and no end-of-packet flag is raised.

Top module: `pkt_deframer`

## Requirements
- R1: The sync pattern is the first `cfg_sync_len` bytes of `cfg_sync_word`, with byte 0 in bits 63:56. The first bit received is compared with bit 7 of byte 0 and the last with bit 0 of the last used byte. `sync_match` goes high on the clock edge that takes the final sync bit.
- R2: A stream that does not contain the sync bytes in that order and bit order never raises `sync_match`. This includes the same bytes in reversed byte order.
- R3: With `cfg_var_len`=0 and `cfg_pay_len`=N>0, exactly N bytes after sync (address byte included) are written to the FIFO. The CRC bytes that follow are not written.
- R4: With `cfg_var_len`=1, the first byte after sync is the length L. L is written to the FIFO, and L further bytes (address byte included) are collected.
- R5: With `cfg_var_len`=0 and `cfg_pay_len`=0, bytes are written without end, `payload_ready` never rises and `sync_match` stays high.
- R6: Address mode 2'b01 keeps a packet only if its first payload byte equals `cfg_node_addr`. On a mismatch the FIFO is emptied and `sync_match` drops on the edge that takes that byte.
- R7: Address mode 2'b10 keeps the node address or `cfg_bcast_addr` and drops other values. Modes 2'b00 and 2'b11 keep every address.
- R8: The CRC register starts at 16'h1D0F, uses polynomial 16'h1021 MSB first over every byte after sync, and the sender transmits its inverse, high byte first. A match raises `payload_ready` and `crc_ok` together.
- R9: On a CRC mismatch with `cfg_crc_keep`=0, the FIFO is emptied, `payload_ready` stays low and `sync_match` drops.
- R10: On a CRC mismatch with `cfg_crc_keep`=1, `payload_ready` rises, `crc_ok` stays low and the bytes stay in the FIFO.
- R11: With `cfg_crc_en`=0 no CRC bytes are expected. `payload_ready` rises on the edge that writes the last byte, with `crc_ok` low.
- R12: After reset the FIFO is empty and all flags are low. The FIFO holds 66 bytes, raises `fifo_full` at 66 and drops further writes. `payload_ready` and `crc_ok` clear one cycle after the FIFO becomes empty.
- R13: In variable format a length byte of zero abandons the packet: the FIFO is emptied and `sync_match` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Recovered data bit |
| bit_en | input | 1 | Qualifies `bit_in` for one cycle |
| cfg_sync_len | input | 4 | Sync pattern length in bytes, 0 to 8 |
| cfg_sync_word | input | 64 | Sync pattern, byte 0 in bits 63:56 |
| cfg_var_len | input | 1 | 0 fixed format, 1 variable format |
| cfg_pay_len | input | 8 | Fixed payload length; 0 means unlimited |
| cfg_addr_mode | input | 2 | Address screen mode |
| cfg_node_addr | input | 8 | Own node address |
| cfg_bcast_addr | input | 8 | Broadcast address |
| cfg_crc_en | input | 1 | CRC field present and checked |
| cfg_crc_keep | input | 1 | Keep packets that fail the CRC |
| fifo_rd | input | 1 | Pops one byte from the FIFO |
| sync_match | output | 1 | High while a packet is being received |
| payload_ready | output | 1 | Kept packet waits in the FIFO |
| crc_ok | output | 1 | Kept packet passed its CRC |
| fifo_wr | output | 1 | Strobe for each payload byte written |
| fifo_rd_data | output | 8 | Byte at the FIFO head |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_full | output | 1 | FIFO holds 66 bytes |

## Verification
Some properties hold on every cycle, and the assertions check those. Bytes are written only inside a packet. An accepted write leaves the FIFO non-empty. `crc_ok` never appears without `payload_ready`. The ready flag falls one cycle after the FIFO drains. A new sync match never overlaps a pending packet. Other behaviour depends on the stream content, and only the directed scenarios show it. These cover sync bit and byte order, the length and address fields, the CRC value with its seed and inversion, the keep-or-flush policy, unlimited reception and FIFO saturation.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;
  typedef enum logic [2:0] {
    ST_SEARCH = 3'd0,
    ST_LEN    = 3'd1,
    ST_ADDR   = 3'd2,
    ST_BODY   = 3'd3,
    ST_CHECK  = 3'd4,
    ST_HOLD   = 3'd5
  } rx_state_e;

  typedef enum logic [1:0] {
    FILT_NONE    = 2'b00,
    FILT_NODE    = 2'b01,
    FILT_NODE_BC = 2'b10,
    FILT_RSVD    = 2'b11
  } addr_filt_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h1D0F;
endpackage

// File: rtl/pkt_sync_match.sv
module pkt_sync_match #(
  parameter int MAX_BYTES = 8,
  localparam int SW = 8 * MAX_BYTES,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int CW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          bit_en,
  input  logic          search,
  input  logic          restart,
  input  logic [LW-1:0] cfg_len,
  input  logic [SW-1:0] cfg_word,
  output logic          hit
);
  logic [SW-1:0] shreg_q, shreg_d, shift_in;
  logic [CW-1:0] seen_q, seen_d, seen_inc, needed;
  logic [LW-1:0] eff_len;
  logic          cmp_ok;

  assign eff_len  = (cfg_len > LW'(MAX_BYTES)) ? LW'(MAX_BYTES) : cfg_len;
  assign needed   = CW'({eff_len, 3'b000});
  assign shift_in = {shreg_q[SW-2:0], bit_in};
  assign seen_inc = (seen_q == CW'(SW)) ? seen_q : seen_q + 1'b1;

  always_comb begin
    cmp_ok = 1'b1;
    for (int i = 0; i < SW; i++) begin
      if (i < int'(needed)) begin
        if (shift_in[i] != cfg_word[SW - int'(needed) + i]) cmp_ok = 1'b0;
      end
    end
  end

  always_comb begin
    if (eff_len == '0) hit = search;
    else hit = search && bit_en && (seen_inc >= needed) && cmp_ok;
  end

  always_comb begin
    shreg_d = shreg_q;
    seen_d  = seen_q;
    if (restart) begin
      seen_d = '0;
    end else if (search && bit_en) begin
      shreg_d = shift_in;
      seen_d  = seen_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      seen_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      seen_q  <= seen_d;
    end
  end
endmodule

// File: rtl/pkt_crc16.sv
module pkt_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'h1D0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        bit_en,
  input  logic        bit_in,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d;
  logic        fb;

  assign fb  = crc_q[15] ^ bit_in;
  assign crc = crc_q;

  always_comb begin
    crc_d = crc_q;
    if (init) crc_d = SEED;
    else if (bit_en) crc_d = {crc_q[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else crc_q <= crc_d;
  end
endmodule

// File: rtl/pkt_byte_fifo.sv
module pkt_byte_fifo #(
  parameter int DEPTH = 66,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign wr_ok   = wr && !full && !clear;
  assign rd_ok   = rd && !empty && !clear;
  assign rd_data = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clear) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_data;
  end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframer_pkg::*;
#(
  parameter int SYNC_MAX_BYTES = 8,
  parameter int FIFO_DEPTH = 66,
  localparam int LW = $clog2(SYNC_MAX_BYTES + 1),
  localparam int SW = 8 * SYNC_MAX_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          bit_en,
  input  logic [LW-1:0] cfg_sync_len,
  input  logic [SW-1:0] cfg_sync_word,
  input  logic          cfg_var_len,
  input  logic [7:0]    cfg_pay_len,
  input  logic [1:0]    cfg_addr_mode,
  input  logic [7:0]    cfg_node_addr,
  input  logic [7:0]    cfg_bcast_addr,
  input  logic          cfg_crc_en,
  input  logic          cfg_crc_keep,
  input  logic          fifo_rd,
  output logic          sync_match,
  output logic          payload_ready,
  output logic          crc_ok,
  output logic          fifo_wr,
  output logic [7:0]    fifo_rd_data,
  output logic          fifo_empty,
  output logic          fifo_full
);
  rx_state_e   state_q, state_d;
  logic [2:0]  bitcnt_q, bitcnt_d;
  logic [7:0]  byte_q, byte_d, byte_nxt;
  logic [7:0]  remain_q, remain_d;
  logic [15:0] rxcrc_q, rxcrc_d, rx_full;
  logic        unlim_q, unlim_d;
  logic        half_q, half_d;
  logic        rdy_q, rdy_d, ok_q, ok_d;
  logic        in_pkt, byte_done, crc_feed, crc_init;
  logic        sync_hit, restart, fifo_clear, wr_req;
  logic        filt_on, addr_pass, last_byte;
  logic [15:0] crc_val;
  addr_filt_e  filt_mode;

  assign filt_mode = addr_filt_e'(cfg_addr_mode);
  assign filt_on   = (filt_mode == FILT_NODE) || (filt_mode == FILT_NODE_BC);
  assign in_pkt    = (state_q == ST_LEN) || (state_q == ST_ADDR) ||
                     (state_q == ST_BODY) || (state_q == ST_CHECK);
  assign byte_nxt  = {byte_q[6:0], bit_in};
  assign byte_done = in_pkt && bit_en && (bitcnt_q == 3'd7);
  assign crc_feed  = bit_en && (state_q == ST_LEN || state_q == ST_ADDR ||
                                state_q == ST_BODY);
  assign rx_full   = {rxcrc_q[14:0], bit_in};
  assign last_byte = !unlim_q && (remain_q == 8'd1);

  always_comb begin
    case (filt_mode)
      FILT_NODE:    addr_pass = (byte_nxt == cfg_node_addr);
      FILT_NODE_BC: addr_pass = (byte_nxt == cfg_node_addr) ||
                                (byte_nxt == cfg_bcast_addr);
      default:      addr_pass = 1'b1;
    endcase
  end

  pkt_sync_match #(.MAX_BYTES(SYNC_MAX_BYTES)) sync_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
    .search(state_q == ST_SEARCH), .restart(restart),
    .cfg_len(cfg_sync_len), .cfg_word(cfg_sync_word), .hit(sync_hit)
  );

  pkt_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) crc_i (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .bit_en(crc_feed),
    .bit_in(bit_in), .crc(crc_val)
  );

  pkt_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .wr(wr_req),
    .wr_data(byte_nxt), .rd(fifo_rd), .rd_data(fifo_rd_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    bitcnt_d   = bitcnt_q;
    byte_d     = byte_q;
    remain_d   = remain_q;
    rxcrc_d    = rxcrc_q;
    unlim_d    = unlim_q;
    half_d     = half_q;
    rdy_d      = rdy_q;
    ok_d       = ok_q;
    crc_init   = 1'b0;
    fifo_clear = 1'b0;
    wr_req     = 1'b0;

    if (in_pkt && bit_en) begin
      bitcnt_d = bitcnt_q + 1'b1;
      byte_d   = byte_nxt;
    end

    case (state_q)
      ST_SEARCH: begin
        if (sync_hit) begin
          crc_init = 1'b1;
          bitcnt_d = '0;
          remain_d = cfg_pay_len;
          unlim_d  = !cfg_var_len && (cfg_pay_len == 8'd0);
          half_d   = 1'b0;
          if (cfg_var_len) state_d = ST_LEN;
          else if (filt_on) state_d = ST_ADDR;
          else state_d = ST_BODY;
        end
      end
      ST_LEN: begin
        if (byte_done) begin
          if (byte_nxt == 8'd0) begin
            fifo_clear = 1'b1;
            state_d    = ST_SEARCH;
          end else begin
            wr_req   = 1'b1;
            remain_d = byte_nxt;
            state_d  = filt_on ? ST_ADDR : ST_BODY;
          end
        end
      end
      ST_ADDR, ST_BODY: begin
        if (byte_done) begin
          if (state_q == ST_ADDR && !addr_pass) begin
            fifo_clear = 1'b1;
            state_d    = ST_SEARCH;
          end else begin
            wr_req = 1'b1;
            if (!unlim_q) remain_d = remain_q - 1'b1;
            if (last_byte) begin
              if (cfg_crc_en) begin
                state_d = ST_CHECK;
                half_d  = 1'b0;
              end else begin
                state_d = ST_HOLD;
                rdy_d   = 1'b1;
                ok_d    = 1'b0;
              end
            end else begin
              state_d = ST_BODY;
            end
          end
        end
      end
      ST_CHECK: begin
        if (bit_en) rxcrc_d = rx_full;
        if (byte_done) begin
          if (!half_q) begin
            half_d = 1'b1;
          end else if (rx_full == ~crc_val) begin
            state_d = ST_HOLD;
            rdy_d   = 1'b1;
            ok_d    = 1'b1;
          end else if (cfg_crc_keep) begin
            state_d = ST_HOLD;
            rdy_d   = 1'b1;
            ok_d    = 1'b0;
          end else begin
            fifo_clear = 1'b1;
            state_d    = ST_SEARCH;
          end
        end
      end
      ST_HOLD: begin
        if (fifo_empty) begin
          state_d = ST_SEARCH;
          rdy_d   = 1'b0;
          ok_d    = 1'b0;
        end
      end
      default: state_d = ST_SEARCH;
    endcase

    restart = (state_d == ST_SEARCH) && (state_q != ST_SEARCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SEARCH;
      bitcnt_q <= '0;
      byte_q   <= '0;
      remain_q <= '0;
      rxcrc_q  <= '0;
      unlim_q  <= 1'b0;
      half_q   <= 1'b0;
      rdy_q    <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      byte_q   <= byte_d;
      remain_q <= remain_d;
      rxcrc_q  <= rxcrc_d;
      unlim_q  <= unlim_d;
      half_q   <= half_d;
      rdy_q    <= rdy_d;
      ok_q     <= ok_d;
    end
  end

  assign sync_match    = in_pkt;
  assign payload_ready = rdy_q;
  assign crc_ok        = ok_q;
  assign fifo_wr       = wr_req;
endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_match,
  input logic payload_ready,
  input logic crc_ok,
  input logic fifo_wr,
  input logic fifo_empty,
  input logic fifo_full
);
  // R8
  crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> payload_ready);

  // R3
  wr_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> sync_match);

  // R12
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !fifo_full) |=> !fifo_empty);

  // R12
  ready_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (payload_ready && fifo_empty) |=> !payload_ready);

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_match) |-> !payload_ready);
endmodule

bind pkt_deframer pkt_deframer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sync_match(sync_match),
  .payload_ready(payload_ready), .crc_ok(crc_ok), .fifo_wr(fifo_wr),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/pkt_deframer_tb_top.sv
module pkt_deframer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_in, bit_en, fifo_rd;
  logic [3:0]  cfg_sync_len;
  logic [63:0] cfg_sync_word;
  logic        cfg_var_len, cfg_crc_en, cfg_crc_keep;
  logic [7:0]  cfg_pay_len, cfg_node_addr, cfg_bcast_addr;
  logic [1:0]  cfg_addr_mode;
  logic        sync_match, payload_ready, crc_ok, fifo_wr, fifo_empty, fifo_full;
  logic [7:0]  fifo_rd_data;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;
  logic [7:0] pk [0:79];
  int pk_n;

  always #4 clk = ~clk;

  pkt_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_word(cfg_sync_word),
    .cfg_var_len(cfg_var_len), .cfg_pay_len(cfg_pay_len),
    .cfg_addr_mode(cfg_addr_mode), .cfg_node_addr(cfg_node_addr),
    .cfg_bcast_addr(cfg_bcast_addr), .cfg_crc_en(cfg_crc_en),
    .cfg_crc_keep(cfg_crc_keep), .fifo_rd(fifo_rd),
    .sync_match(sync_match), .payload_ready(payload_ready), .crc_ok(crc_ok),
    .fifo_wr(fifo_wr), .fifo_rd_data(fifo_rd_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (!cond) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h1D0F;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ pk[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int b = 7; b >= 0; b--) send_bit(v[b]);
  endtask

  task automatic send_sync();
    for (int i = 0; i < int'(cfg_sync_len); i++)
      send_byte(cfg_sync_word[63 - 8*i -: 8]);
  endtask

  task automatic send_pkt(input bit with_crc, input logic [15:0] corrupt);
    logic [15:0] c;
    send_sync();
    for (int i = 0; i < pk_n; i++) send_byte(pk[i]);
    if (with_crc) begin
      c = ~ref_crc(pk_n) ^ corrupt;
      send_byte(c[15:8]);
      send_byte(c[7:0]);
    end
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      expect_eq(req, "fifo byte", fifo_rd_data, pk[i]);
      fifo_rd = 1'b1;
      @(negedge clk);
      fifo_rd = 1'b0;
    end
    expect_eq(req, "fifo empty after drain", fifo_empty, 1'b1);
    idle(2);
  endtask

  task automatic set_default();
    cfg_sync_len   = 4'd2;
    cfg_sync_word  = {8'h2D, 8'hD4, 48'h0};
    cfg_var_len    = 1'b0;
    cfg_pay_len    = 8'd4;
    cfg_addr_mode  = 2'b00;
    cfg_node_addr  = 8'h42;
    cfg_bcast_addr = 8'hFF;
    cfg_crc_en     = 1'b1;
    cfg_crc_keep   = 1'b0;
  endtask

  task automatic do_reset();
    bit_in = 1'b0; bit_en = 1'b0; fifo_rd = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset();
    expect_eq("R12", "reset sync_match", sync_match, 1'b0);
    expect_eq("R12", "reset payload_ready", payload_ready, 1'b0);
    expect_eq("R12", "reset crc_ok", crc_ok, 1'b0);
    expect_eq("R12", "reset fifo_empty", fifo_empty, 1'b1);
    expect_eq("R12", "reset fifo_full", fifo_full, 1'b0);
  endtask

  task automatic t_sync_order();
    set_default();
    send_byte(8'hAA);
    send_byte(8'hD4);
    send_byte(8'h2D);
    send_byte(8'hAA);
    expect_eq("R2", "reversed sync rejected", sync_match, 1'b0);
    send_byte(8'h2D);
    for (int b = 7; b >= 1; b--) send_bit(cfg_sync_word[48 + b]);
    expect_eq("R1", "sync not before last bit", sync_match, 1'b0);
    send_bit(cfg_sync_word[48]);
    expect_eq("R1", "sync after last bit", sync_match, 1'b1);
    pk[0] = 8'h01; pk[1] = 8'h02; pk[2] = 8'h03; pk[3] = 8'h04; pk_n = 4;
    for (int i = 0; i < 4; i++) send_byte(pk[i]);
    begin
      logic [15:0] c = ~ref_crc(4);
      send_byte(c[15:8]); send_byte(c[7:0]);
    end
    expect_eq("R8", "ready after sync packet", payload_ready, 1'b1);
    drain(4, "R1");
  endtask

  task automatic t_fixed_crc();
    set_default();
    pk[0] = 8'h11; pk[1] = 8'h22; pk[2] = 8'h33; pk[3] = 8'h44; pk_n = 4;
    send_byte(8'h55);
    send_pkt(1'b1, 16'h0);
    expect_eq("R8", "payload_ready", payload_ready, 1'b1);
    expect_eq("R8", "crc_ok", crc_ok, 1'b1);
    expect_eq("R3", "sync_match low after packet", sync_match, 1'b0);
    drain(4, "R3");
    expect_eq("R12", "ready clears after drain", payload_ready, 1'b0);
    expect_eq("R12", "crc_ok clears after drain", crc_ok, 1'b0);
  endtask

  task automatic t_variable();
    set_default();
    cfg_var_len = 1'b1;
    pk[0] = 8'd3; pk[1] = 8'hA1; pk[2] = 8'hB2; pk[3] = 8'hC3; pk_n = 4;
    send_pkt(1'b1, 16'h0);
    expect_eq("R4", "var payload_ready", payload_ready, 1'b1);
    expect_eq("R4", "var crc_ok", crc_ok, 1'b1);
    drain(4, "R4");
  endtask

  task automatic t_zero_len();
    set_default();
    cfg_var_len = 1'b1;
    send_sync();
    send_byte(8'h00);
    expect_eq("R13", "zero length drops sync", sync_match, 1'b0);
    expect_eq("R13", "zero length fifo empty", fifo_empty, 1'b1);
    idle(4);
  endtask

  task automatic t_addr_node();
    set_default();
    cfg_addr_mode = 2'b01; cfg_pay_len = 8'd3;
    send_sync();
    send_byte(8'h41);
    expect_eq("R6", "mismatch drops sync", sync_match, 1'b0);
    expect_eq("R6", "mismatch fifo empty", fifo_empty, 1'b1);
    idle(4);
    pk[0] = 8'h42; pk[1] = 8'h05; pk[2] = 8'h06; pk_n = 3;
    send_pkt(1'b1, 16'h0);
    expect_eq("R6", "node match kept", payload_ready, 1'b1);
    drain(3, "R6");
  endtask

  task automatic t_addr_bcast();
    set_default();
    cfg_addr_mode = 2'b10; cfg_pay_len = 8'd3;
    pk[0] = 8'hFF; pk[1] = 8'h09; pk[2] = 8'h08; pk_n = 3;
    send_pkt(1'b1, 16'h0);
    expect_eq("R7", "broadcast kept", payload_ready, 1'b1);
    drain(3, "R7");
    send_sync();
    send_byte(8'h13);
    expect_eq("R7", "other address dropped in mode 10", sync_match, 1'b0);
    idle(4);
    cfg_addr_mode = 2'b11;
    pk[0] = 8'h13; pk[1] = 8'h77; pk[2] = 8'h66; pk_n = 3;
    send_pkt(1'b1, 16'h0);
    expect_eq("R7", "mode 11 keeps any address", crc_ok, 1'b1);
    drain(3, "R7");
  endtask

  task automatic t_crc_drop();
    set_default();
    pk[0] = 8'hDE; pk[1] = 8'hAD; pk[2] = 8'hBE; pk[3] = 8'hEF; pk_n = 4;
    send_pkt(1'b1, 16'h0100);
    expect_eq("R9", "bad crc no ready", payload_ready, 1'b0);
    expect_eq("R9", "bad crc fifo flushed", fifo_empty, 1'b1);
    expect_eq("R9", "bad crc sync dropped", sync_match, 1'b0);
    idle(4);
  endtask

  task automatic t_crc_keep();
    set_default();
    cfg_crc_keep = 1'b1;
    pk[0] = 8'h10; pk[1] = 8'h20; pk[2] = 8'h30; pk[3] = 8'h40; pk_n = 4;
    send_pkt(1'b1, 16'h0001);
    expect_eq("R10", "kept ready", payload_ready, 1'b1);
    expect_eq("R10", "kept crc_ok low", crc_ok, 1'b0);
    drain(4, "R10");
  endtask

  task automatic t_no_crc();
    set_default();
    cfg_crc_en = 1'b0; cfg_pay_len = 8'd2;
    pk[0] = 8'h5A; pk[1] = 8'hA5; pk_n = 2;
    send_sync();
    send_byte(pk[0]);
    expect_eq("R11", "not ready before last byte", payload_ready, 1'b0);
    send_byte(pk[1]);
    expect_eq("R11", "ready after last byte", payload_ready, 1'b1);
    expect_eq("R11", "crc_ok low without crc", crc_ok, 1'b0);
    drain(2, "R11");
  endtask

  task automatic t_long_sync();
    set_default();
    cfg_sync_len  = 4'd8;
    cfg_sync_word = 64'hC35A96E10FF03CA5;
    cfg_pay_len   = 8'd1;
    send_byte(8'h00);
    for (int i = 0; i < 8; i++) begin
      if (i < 7) send_byte(cfg_sync_word[63 - 8*i -: 8]);
      else for (int b = 7; b >= 1; b--) send_bit(cfg_sync_word[b]);
    end
    expect_eq("R1", "long sync not yet", sync_match, 1'b0);
    send_bit(cfg_sync_word[0]);
    expect_eq("R1", "long sync matched", sync_match, 1'b1);
    pk[0] = 8'h99; pk_n = 1;
    send_byte(pk[0]);
    begin
      logic [15:0] c = ~ref_crc(1);
      send_byte(c[15:8]); send_byte(c[7:0]);
    end
    expect_eq("R8", "long sync packet crc_ok", crc_ok, 1'b1);
    drain(1, "R1");
  endtask

  task automatic t_unlimited();
    set_default();
    cfg_pay_len = 8'd0;
    for (int i = 0; i < 70; i++) pk[i] = 8'(i + 3);
    pk_n = 70;
    send_pkt(1'b0, 16'h0);
    expect_eq("R12", "fifo full at 66", fifo_full, 1'b1);
    expect_eq("R5", "unlimited keeps sync", sync_match, 1'b1);
    expect_eq("R5", "unlimited no ready", payload_ready, 1'b0);
    drain(66, "R12");
    expect_eq("R5", "unlimited still no ready", payload_ready, 1'b0);
    do_reset();
    t_reset();
  endtask

  initial begin
    set_default();
    do_reset();
    t_reset();
    t_sync_order();
    t_fixed_crc();
    t_variable();
    t_zero_len();
    t_addr_node();
    t_addr_bcast();
    t_crc_drop();
    t_crc_keep();
    t_no_crc();
    t_long_sync();
    t_unlimited();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule